// File: doc/BRIEF.md
# Bus-Attached Successive-Approximation Conversion Controller

This block is the digital half of an 8-bit successive-approximation converter that a microprocessor addresses like a memory location or an I/O port. The host starts a conversion by pulsing an active-low write strobe while the chip select is low. The block then runs a bit-by-bit search against a single-bit comparator input and stores the final code in a result register. It signals completion on an active-low interrupt line. The host reads the code back by pulling chip select and the read strobe low, which also enables the tri-state data bus.

The strobes are asynchronous to the system clock, so the block synchronises them before it uses them. A write held low keeps the search in reset, and the conversion begins when the write is released. The interrupt is cleared by a new write, or by a read that comes late enough after completion. If the interrupt output is wired back to the write input, the block runs free and restarts after every result. The present trial code is driven out so that an external ladder and comparator can be modelled around the block.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, intr_n is high, data_oe is low and data_out reads 0x00.
- R2: While cs_n and wr_n are both low, no conversion runs or completes, however long that lasts, and intr_n stays high.
- R3: intr_n falls between 66 and 73 clock cycles after the rising edge of wr_n that releases a write with cs_n low. With the default parameters the figure is exactly 69.
- R4: The search decides the MSB first and gives each bit an 8-cycle window. In the last cycle of the window it samples cmp_in: 1 keeps the trial bit, meaning the input is above trial_code, and 0 clears it. The final code is therefore the largest code below the input. A comparator that is always 0 gives 0x00, and one that is always 1 gives 0xFF.
- R5: The result register changes only when a conversion completes. A read during a conversion returns the previous result.
- R6: data_oe is high exactly while cs_n and rd_n are both low, with no clock delay. While data_oe is high, data_out carries the result register. Otherwise data_out is 0x00.
- R7: A falling edge of wr_n with cs_n low returns intr_n high 3 clock cycles later.
- R8: A falling edge of rd_n with cs_n low clears intr_n if it arrives 8 or more cycles after intr_n fell. A read edge that arrives sooner leaves intr_n low.
- R9: With wr_n driven from intr_n and cs_n held low, the block restarts a conversion after each completion, about every 72 cycles.
- R10: With cs_n high, pulses on wr_n and rd_n start no conversion, do not clear intr_n and do not enable the data bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| wr_n | input | 1 | Active-low write / start strobe (asynchronous) |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| cmp_in | input | 1 | Comparator result: 1 when the input exceeds trial_code |
| trial_code | output | DATA_W | Code currently offered to the external ladder |
| data_out | output | DATA_W | Result value for the bus, 0 when not enabled |
| data_oe | output | 1 | Tri-state enable for the data bus |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit code, two synchroniser stages, two alignment cycles, eight cycles per bit and an eight-cycle read guard. With these values the write-to-interrupt latency is exactly 69 cycles, inside the 66 to 73 window, and a free-running loop has a period short enough that several completions fit in a few hundred cycles. A read pulse issued right after the interrupt reaches the logic while the guard counter is still at 2, so the ignored-read case can be tested. The comparator is modelled from an integer input level compared against trial_code, which covers codes 0x00 and 0xFF, both sides of the MSB, and alternating bit patterns.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALIGN  = 2'd1,
        ST_SEARCH = 2'd2
    } conv_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int CHAIN_W = STAGES * WIDTH;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[WIDTH-1:0] = async_in;
        end else begin : g_next
            assign chain_d[g*WIDTH +: WIDTH] = chain_q[(g-1)*WIDTH +: WIDTH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ALIGN_CYC = 2,
    parameter int BIT_CYC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              start,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] trial,
    output logic [DATA_W-1:0] result,
    output logic              busy,
    output logic              done
);
    localparam int ALN_W = $clog2(ALIGN_CYC + 1);
    localparam int SUB_W = $clog2(BIT_CYC + 1);
    localparam logic [ALN_W-1:0]  ALN_LAST = ALN_W'(ALIGN_CYC - 1);
    localparam logic [SUB_W-1:0]  SUB_LAST = SUB_W'(BIT_CYC - 1);
    localparam logic [DATA_W-1:0] TOP_BIT  = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        conv_state_e       st;
        logic [ALN_W-1:0]  aln;
        logic [SUB_W-1:0]  sub;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] result;
    } srch_t;

    srch_t s_d, s_q;
    logic  done_w;

    always_comb begin
        s_d    = s_q;
        done_w = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st  = ST_ALIGN;
                    s_d.aln = '0;
                end
            end
            ST_ALIGN: begin
                if (s_q.aln == ALN_LAST) begin
                    s_d.st   = ST_SEARCH;
                    s_d.sub  = '0;
                    s_d.acc  = '0;
                    s_d.mask = TOP_BIT;
                end else begin
                    s_d.aln = s_q.aln + 1'b1;
                end
            end
            ST_SEARCH: begin
                if (s_q.sub == SUB_LAST) begin
                    s_d.sub  = '0;
                    s_d.mask = s_q.mask >> 1;
                    if (cmp_in) s_d.acc = s_q.acc | s_q.mask;
                    if (s_q.mask[0]) begin
                        done_w     = 1'b1;
                        s_d.st     = ST_IDLE;
                        s_d.result = cmp_in ? (s_q.acc | s_q.mask) : s_q.acc;
                    end
                end else begin
                    s_d.sub = s_q.sub + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (hold) begin
            s_d.st   = ST_IDLE;
            s_d.mask = '0;
            s_d.acc  = '0;
            s_d.sub  = '0;
            s_d.aln  = '0;
            s_d.result = s_q.result;
            done_w   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign trial  = s_q.acc | s_q.mask;
    assign result = s_q.result;
    assign busy   = (s_q.st != ST_IDLE);
    assign done   = done_w;

    // R2: a held write leaves the search idle on the next cycle
    a_r2_hold_idles: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !busy);

    // R4: exactly one trial bit is live throughout the search
    a_r4_single_trial: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SEARCH) |-> ($countones(s_q.mask) == 1));

    // R5: result register moves only on completion
    a_r5_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !done_w |=> $stable(s_q.result));
endmodule

// File: rtl/sar_irq.sv
module sar_irq #(
    parameter int RD_GUARD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic done,
    input  logic rd_evt,
    output logic irq
);
    localparam int AGE_W = $clog2(RD_GUARD + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RD_GUARD);

    typedef struct packed {
        logic             active;
        logic [AGE_W-1:0] age;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (i_q.active && i_q.age != AGE_MAX) i_d.age = i_q.age + 1'b1;
        if (hold) begin
            i_d.active = 1'b0;
        end else if (done) begin
            i_d.active = 1'b1;
            i_d.age    = '0;
        end else if (rd_evt && i_q.age == AGE_MAX) begin
            i_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign irq = i_q.active;

    // R7: a write access withdraws the interrupt
    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !irq);

    // R3: completion raises the interrupt
    a_r3_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hold) |=> irq);

    // R8: inside the guard window only a write can clear
    a_r8_guard_window: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && i_q.age != AGE_MAX && !hold) |=> irq);
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ALIGN_CYC   = 2,
    parameter int BIT_CYC     = 8,
    parameter int RD_GUARD    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] trial_code,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              intr_n
);
    localparam int STROBES = 3;

    typedef struct packed {
        logic wr_sel;
        logic rd_sel;
    } edge_t;

    logic [STROBES-1:0] strobe_s;
    logic               cs_s, wr_s, rd_s;
    logic               sel_wr, sel_rd, start_w, rd_evt_w;
    logic               busy, done, irq;
    logic [DATA_W-1:0]  result;
    edge_t              e_d, e_q;

    sar_sync #(
        .WIDTH   (STROBES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('1)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, wr_n, rd_n}),
        .sync_out (strobe_s)
    );

    assign {cs_s, wr_s, rd_s} = strobe_s;

    always_comb begin
        sel_wr     = !cs_s && !wr_s;
        sel_rd     = !cs_s && !rd_s;
        e_d.wr_sel = sel_wr;
        e_d.rd_sel = sel_rd;
        start_w    = e_q.wr_sel && !sel_wr;
        rd_evt_w   = sel_rd && !e_q.rd_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    sar_search #(
        .DATA_W    (DATA_W),
        .ALIGN_CYC (ALIGN_CYC),
        .BIT_CYC   (BIT_CYC)
    ) i_search (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (sel_wr),
        .start  (start_w),
        .cmp_in (cmp_in),
        .trial  (trial_code),
        .result (result),
        .busy   (busy),
        .done   (done)
    );

    sar_irq #(
        .RD_GUARD (RD_GUARD)
    ) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (sel_wr),
        .done   (done),
        .rd_evt (rd_evt_w),
        .irq    (irq)
    );

    assign data_oe  = !cs_n && !rd_n;
    assign data_out = data_oe ? result : '0;
    assign intr_n   = !irq;

    // R6: a sustained read sees a steady value unless a result lands
    a_r6_read_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe) && !$past(done)) |-> $stable(data_out));

    // R10: a deselected device never launches a search
    a_r10_no_start_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !start_w);

    // R9: the interrupt is never pending while a search runs
    a_r9_idle_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq);
endmodule

// File: tb/test_sar_bus_ctrl.sv
`timescale 1ns/1ps
module test_sar_bus_ctrl;
    localparam int DW   = 8;
    localparam int NVEC = 10;
    localparam int VEC_AIN [NVEC] = '{0, 1, 2, 128, 129, 171, 86, 255, 256, 300};
    localparam int VEC_EXP [NVEC] = '{0, 0, 1, 127, 128, 170, 85, 254, 255, 255};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, cs_n, wr_drv, rd_n, freerun, finished;
    logic          wr_n, cmp;
    logic [DW-1:0] trial, data_out;
    logic          data_oe, intr_n;
    int            ain;
    int            checks = 0;
    int            errors = 0;

    assign wr_n = freerun ? intr_n : wr_drv;
    assign cmp  = (ain > int'(trial));

    sar_bus_ctrl i_sar_bus_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .cmp_in     (cmp),
        .trial_code (trial),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .intr_n     (intr_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pulse a write, then count cycles from release until intr_n falls
    task automatic convert(input int a, output int lat);
        ain = a; cs_n = 1'b0; wr_drv = 1'b0;
        cyc(4);
        wr_drv = 1'b1; lat = 0;
        while (intr_n && lat < 200) begin
            cyc(1); lat++;
        end
        cs_n = 1'b1;
    endtask

    // late read: returns data and the enable, checks the clear
    task automatic late_read(input int exp, input string req);
        cyc(10);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk(data_oe == 1'b1, "R6 oe during read", int'(data_oe), 1);
        chk(data_out == exp[DW-1:0], req, int'(data_out), exp);
        cyc(4);
        chk(intr_n == 1'b1, "R8 late read clears", int'(intr_n), 1);
        rd_n = 1'b1; cs_n = 1'b1; #1;
        chk(data_oe == 1'b0 && data_out == '0, "R6 bus idle after read", int'(data_out), 0);
    endtask

    initial begin
        finished = 1'b0;
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat, falls;
        logic prev_i;
        rst_n = 1'b0; cs_n = 1'b1; wr_drv = 1'b1; rd_n = 1'b1; freerun = 1'b0; ain = 0;
        cyc(5);
        chk(intr_n == 1'b1, "R1 intr_n after reset", int'(intr_n), 1);
        chk(data_oe == 1'b0, "R1 data_oe after reset", int'(data_oe), 0);
        chk(data_out == '0, "R1 data_out after reset", int'(data_out), 0);
        rst_n = 1'b1;
        cyc(3);

        // table walk: R3 latency, R4 code, R6/R8 read path
        for (int i = 0; i < NVEC; i++) begin
            convert(VEC_AIN[i], lat);
            chk(lat >= 66 && lat <= 73, "R3 latency window", lat, 69);
            chk(lat == 69, "R3 default latency", lat, 69);
            late_read(VEC_EXP[i], "R4 converted code");
        end

        // R5: read in mid-conversion returns the previous code (255)
        ain = 60; cs_n = 1'b0; wr_drv = 1'b0;
        cyc(4);
        wr_drv = 1'b1;
        cyc(30);
        rd_n = 1'b0; #1;
        chk(data_out == 8'd255, "R5 old code during conversion", int'(data_out), 255);
        cyc(1); rd_n = 1'b1;
        lat = 31;
        while (intr_n && lat < 200) begin cyc(1); lat++; end
        chk(lat == 69, "R3 latency with mid read", lat, 69);
        // R8: early read pulse right after assertion is ignored
        rd_n = 1'b0; cyc(1); rd_n = 1'b1;
        cyc(6);
        chk(intr_n == 1'b0, "R8 early read ignored", int'(intr_n), 0);
        cs_n = 1'b1;
        late_read(59, "R5 new code after completion");

        // R7 and R2: write clears, long hold runs nothing
        convert(171, lat);
        ain = 86; cs_n = 1'b0; wr_drv = 1'b0;
        cyc(3);
        chk(intr_n == 1'b1, "R7 write clears intr", int'(intr_n), 1);
        falls = 0;
        for (int k = 0; k < 150; k++) begin
            cyc(1);
            if (!intr_n) falls++;
        end
        chk(falls == 0, "R2 hold keeps idle", falls, 0);
        wr_drv = 1'b1; lat = 0;
        while (intr_n && lat < 200) begin cyc(1); lat++; end
        chk(lat == 69, "R2 release starts conversion", lat, 69);
        cs_n = 1'b1;
        late_read(85, "R4 code after hold");

        // R10: strobes with cs_n high
        convert(2, lat);
        ain = 256;
        wr_drv = 1'b0; cyc(5); wr_drv = 1'b1;
        rd_n = 1'b0; #1;
        chk(data_oe == 1'b0, "R10 no enable deselected", int'(data_oe), 0);
        chk(data_out == '0, "R10 bus zero deselected", int'(data_out), 0);
        cyc(5); rd_n = 1'b1;
        cyc(100);
        chk(intr_n == 1'b0, "R10 intr kept", int'(intr_n), 0);
        late_read(1, "R10 no new conversion");

        // R9: free-running loop
        ain = 129; cs_n = 1'b0; wr_drv = 1'b0;
        cyc(4);
        freerun = 1'b1;
        falls = 0; prev_i = intr_n;
        for (int k = 0; k < 500; k++) begin
            cyc(1);
            if (prev_i && !intr_n) falls++;
            prev_i = intr_n;
        end
        chk(falls >= 6, "R9 free-run completions", falls, 6);
        freerun = 1'b0; wr_drv = 1'b1;
        cyc(120);
        chk(intr_n == 1'b0, "R9 final completion", int'(intr_n), 0);
        cs_n = 1'b1;
        late_read(128, "R9 free-run code");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule